// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It sequences the analog switches around an external integrator. First it discharges the integrator capacitor. Next it applies the unknown input for a fixed window of 2^N clocks. Finally it applies a reference of the polarity that drives the integrator back toward zero, and counts clocks until an external comparator reports the zero crossing. That count is the magnitude of the result. The integrator's sign, captured when the fixed window ends, is reported beside it. Only clock counts enter the result, so no calibration constants are needed.

Both analog status bits, the zero-crossing comparator and the integrator polarity, arrive asynchronously and pass through a two-stage synchronizer. The measured count therefore includes a constant synchronizer offset, which downstream scaling removes. A switch selection is never handed directly to another: an idle cycle with every select low always sits between them. If no crossing arrives within 2^N run-down clocks, the conversion ends as out of range.

Top module: `dsadc_ctrl`

## Requirements
- R1: After reset all four switch selects are low, `done_o` is low, and `mag_o`, `sign_o` and `ovr_o` are zero.
- R2: A `start_i` pulse seen in idle raises `sw_dischg_o` on the next clock edge and holds it for exactly RST_CYCLES consecutive cycles (16 by default).
- R3: No two selects are ever high together. When the selection moves from discharge to input, or from input to reference, exactly one cycle with all selects low lies between them.
- R4: `sw_inp_o` is high for exactly 2^N consecutive cycles per conversion.
- R5: The synchronized `integ_neg_i` (1 means the integrator output is negative) is captured in the idle cycle after run-up. A 1 selects `sw_refn_o` for run-down and a 0 selects `sw_refp_o`. `sign_o` reports the captured bit.
- R6: Run-down ends in the first cycle in which the synchronized `zero_cmp_i` is high. `mag_o` equals the number of run-down cycles before that cycle, and `ovr_o` is 0.
- R7: If 2^N run-down cycles pass without a synchronized crossing, run-down ends after the 2^N-th reference cycle with `ovr_o` = 1 and `mag_o` all ones. A crossing seen in the 2^N-th cycle still gives a normal result of 2^N-1.
- R8: `done_o` is a one-cycle pulse. It goes high in the cycle after the first cycle in which the reference selects are low again. `mag_o`, `sign_o` and `ovr_o` change only together with `done_o` and hold their values in between.
- R9: A `start_i` pulse during a conversion has no effect: the switch sequence and the result are unchanged, and no second conversion follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; all timing counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, acted on only in idle |
| zero_cmp_i | input | 1 | Asynchronous comparator bit, high once the integrator has returned to zero |
| integ_neg_i | input | 1 | Asynchronous integrator polarity, high when the output is negative |
| sw_dischg_o | output | 1 | Closes the capacitor discharge switch |
| sw_inp_o | output | 1 | Routes the unknown input to the integrator |
| sw_refp_o | output | 1 | Routes the positive reference to the integrator |
| sw_refn_o | output | 1 | Routes the negative reference to the integrator |
| done_o | output | 1 | One-cycle pulse marking a new result |
| mag_o | output | RES_BITS | Run-down clock count, all ones when out of range |
| sign_o | output | 1 | Captured integrator polarity, 1 for negative |
| ovr_o | output | 1 | Result is out of range |

## Verification
The hardest case to reach is the edge of the range. Here the synchronized crossing either arrives in the very last permitted run-down cycle, or arrives one cycle too late and must become an out-of-range result. Reaching it needs an integrator whose crossing lands on an exact clock. The bench model therefore adds the input value on each run-up cycle and removes 2^N per reference cycle, so an input of magnitude k crosses zero exactly on the k-th run-down cycle. Directed inputs of magnitude 2^N-2 and 2^N-1 then land on either side of the limit. Extra start pulses placed inside run-up check that a busy conversion ignores them.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    // Sequencer phases, in the order a conversion walks through them.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DISCHG,
        PH_GAP_UP,
        PH_RUNUP,
        PH_GAP_DN,
        PH_RUNDN
    } phase_e;

    // One bit per analog switch.
    typedef struct packed {
        logic dischg;
        logic inp;
        logic refp;
        logic refn;
    } sw_sel_t;

    // Switch selection for a phase; both gap phases select nothing.
    function automatic sw_sel_t sel_for(input phase_e ph, input logic neg);
        sw_sel_t s;
        s = '0;
        case (ph)
            PH_DISCHG: s.dischg = 1'b1;
            PH_RUNUP:  s.inp    = 1'b1;
            PH_RUNDN: begin
                s.refn = neg;
                s.refp = ~neg;
            end
            default:   s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int RES_BITS   = 8,
    parameter int RST_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                zero_sync_i,
    input  logic                neg_sync_i,
    output sw_sel_t             sw_o,
    output logic                fin_o,
    output logic                ovr_o,
    output logic                neg_o,
    output logic [RES_BITS-1:0] res_o
);

    localparam int FS  = 1 << RES_BITS;
    localparam int TOP = (RST_CYCLES > FS) ? RST_CYCLES : FS;
    localparam int CW  = $clog2(TOP) + 1;
    localparam logic [CW-1:0] RST_LAST = CW'(RST_CYCLES - 1);
    localparam logic [CW-1:0] FS_LAST  = CW'(FS - 1);

    typedef struct packed {
        phase_e              ph;
        logic [CW-1:0]       cnt;
        logic                neg;
        sw_sel_t             sw;
        logic                fin;
        logic                ovr;
        logic [RES_BITS-1:0] res;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        st_d.ovr = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph  = PH_DISCHG;
                    st_d.cnt = '0;
                end
            end
            PH_DISCHG: begin
                if (st_q.cnt == RST_LAST) begin
                    st_d.ph  = PH_GAP_UP;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_GAP_UP: begin
                st_d.ph  = PH_RUNUP;
                st_d.cnt = '0;
            end
            PH_RUNUP: begin
                if (st_q.cnt == FS_LAST) begin
                    st_d.ph  = PH_GAP_DN;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_GAP_DN: begin
                st_d.neg = neg_sync_i;
                st_d.ph  = PH_RUNDN;
                st_d.cnt = '0;
            end
            PH_RUNDN: begin
                if (zero_sync_i) begin
                    st_d.fin = 1'b1;
                    st_d.res = st_q.cnt[RES_BITS-1:0];
                    st_d.ph  = PH_IDLE;
                end else if (st_q.cnt == FS_LAST) begin
                    st_d.fin = 1'b1;
                    st_d.ovr = 1'b1;
                    st_d.res = '1;
                    st_d.ph  = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
        st_d.sw = sel_for(st_d.ph, st_d.neg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_o  = st_q.sw;
    assign fin_o = st_q.fin;
    assign ovr_o = st_q.ovr;
    assign neg_o = st_q.neg;
    assign res_o = st_q.res;

    // R3: a live selection is only ever followed by itself or by nothing
    p_bbm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sw != '0 && $past(st_q.sw) != '0) |-> st_q.sw == $past(st_q.sw));

    // R4: the run-up timer advances by one each cycle it stays in run-up
    p_runup_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUNUP && $past(st_q.ph) == PH_RUNUP)
        |-> st_q.cnt == $past(st_q.cnt) + CW'(1));

    // R5: polarity used in run-down is the synchronized bit at run-up end
    p_polarity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUNDN && $past(st_q.ph) == PH_GAP_DN)
        |-> st_q.neg == $past(neg_sync_i));

    // R6: a synchronized crossing ends run-down with a normal result
    p_stop_on_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUNDN && zero_sync_i)
        |=> (st_q.ph == PH_IDLE && st_q.fin && !st_q.ovr));

    // R7: out of range only after the last permitted run-down cycle
    p_ovr_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fin && st_q.ovr)
        |-> ($past(st_q.ph) == PH_RUNDN && $past(st_q.cnt) == FS_LAST));

    // R9: a running conversion is never diverted out of run-up
    p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.ph) == PH_RUNUP)
        |-> (st_q.ph == PH_RUNUP || st_q.ph == PH_GAP_DN));

endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
    parameter int RES_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fin_i,
    input  logic                ovr_i,
    input  logic                neg_i,
    input  logic [RES_BITS-1:0] res_i,
    output logic                done_o,
    output logic [RES_BITS-1:0] mag_o,
    output logic                sign_o,
    output logic                ovr_o
);

    typedef struct packed {
        logic                done;
        logic [RES_BITS-1:0] mag;
        logic                sign;
        logic                ovr;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.done = fin_i;
        if (fin_i) begin
            out_d.mag  = res_i;
            out_d.sign = neg_i;
            out_d.ovr  = ovr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign done_o = out_q.done;
    assign mag_o  = out_q.mag;
    assign sign_o = out_q.sign;
    assign ovr_o  = out_q.ovr;

    // R8: done never lasts two cycles
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.done |=> !out_q.done);

    // R8: the result fields only move together with done
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.done |-> ($stable(out_q.mag) && $stable(out_q.sign) && $stable(out_q.ovr)));

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
    import dsadc_pkg::*;
#(
    parameter int RES_BITS    = 8,
    parameter int RST_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                zero_cmp_i,
    input  logic                integ_neg_i,
    output logic                sw_dischg_o,
    output logic                sw_inp_o,
    output logic                sw_refp_o,
    output logic                sw_refn_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] mag_o,
    output logic                sign_o,
    output logic                ovr_o
);

    logic [1:0]          status_sync;
    sw_sel_t             sw_sel;
    logic                fin;
    logic                fin_ovr;
    logic                fin_neg;
    logic [RES_BITS-1:0] fin_res;

    dsadc_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({zero_cmp_i, integ_neg_i}),
        .sync_o  (status_sync)
    );

    dsadc_seq #(
        .RES_BITS   (RES_BITS),
        .RST_CYCLES (RST_CYCLES)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .zero_sync_i (status_sync[1]),
        .neg_sync_i  (status_sync[0]),
        .sw_o        (sw_sel),
        .fin_o       (fin),
        .ovr_o       (fin_ovr),
        .neg_o       (fin_neg),
        .res_o       (fin_res)
    );

    dsadc_result #(
        .RES_BITS (RES_BITS)
    ) i_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .fin_i  (fin),
        .ovr_i  (fin_ovr),
        .neg_i  (fin_neg),
        .res_i  (fin_res),
        .done_o (done_o),
        .mag_o  (mag_o),
        .sign_o (sign_o),
        .ovr_o  (ovr_o)
    );

    assign sw_dischg_o = sw_sel.dischg;
    assign sw_inp_o    = sw_sel.inp;
    assign sw_refp_o   = sw_sel.refp;
    assign sw_refn_o   = sw_sel.refn;

endmodule

// File: tb/test_dsadc_ctrl.sv
module test_dsadc_ctrl;

    localparam int N   = 8;
    localparam int RST = 16;
    localparam int FS  = 1 << N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         zero_cmp_i = 1'b0;
    logic         integ_neg_i = 1'b0;
    logic         sw_dischg_o, sw_inp_o, sw_refp_o, sw_refn_o;
    logic         done_o, sign_o, ovr_o;
    logic [N-1:0] mag_o;

    always #2 clk = ~clk;

    dsadc_ctrl #(
        .RES_BITS    (N),
        .RST_CYCLES  (RST),
        .SYNC_STAGES (2)
    ) i_dsadc_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .zero_cmp_i  (zero_cmp_i),
        .integ_neg_i (integ_neg_i),
        .sw_dischg_o (sw_dischg_o),
        .sw_inp_o    (sw_inp_o),
        .sw_refp_o   (sw_refp_o),
        .sw_refn_o   (sw_refn_o),
        .done_o      (done_o),
        .mag_o       (mag_o),
        .sign_o      (sign_o),
        .ovr_o       (ovr_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // behavioural integrator and switch monitor state
    int       acc = 0;
    int       vin = 0;
    logic [3:0] sel;
    logic [3:0] prev_sel = 4'b0000;
    logic [3:0] last_nz  = 4'b0000;
    int       zeros = 100;
    int       len_rst, len_in, len_ref, bbm_err, gap_err, done_cnt;
    bit       refp_seen, refn_seen;
    logic [N-1:0] last_mag = '0;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Integrator: input adds vin per cycle, each reference cycle removes FS
    // in the direction of zero, so magnitude k crosses on the k-th cycle.
    always @(negedge clk) begin
        sel = {sw_dischg_o, sw_inp_o, sw_refp_o, sw_refn_o};
        if (sel[3])      acc = 0;
        else if (sel[2]) acc = acc + vin;
        else if (sel[1]) acc = acc - FS;
        else if (sel[0]) acc = acc + FS;
        integ_neg_i = (acc < 0);
        zero_cmp_i  = (sel[1] && acc <= 0) || (sel[0] && acc >= 0);
        if (sel != 4'b0000) begin
            if (prev_sel != 4'b0000 && prev_sel != sel) bbm_err++;
            if (prev_sel == 4'b0000 && sel != 4'b1000 && zeros != 1) gap_err++;
            case (sel)
                4'b1000: len_rst++;
                4'b0100: len_in++;
                4'b0010: begin len_ref++; refp_seen = 1'b1; end
                4'b0001: begin len_ref++; refn_seen = 1'b1; end
                default: bbm_err++;
            endcase
            zeros   = 0;
            last_nz = sel;
        end else begin
            zeros++;
        end
        prev_sel = sel;
        if (done_o) done_cnt++;
    end

    task automatic conv(input int v, input bit poke);
        int a;
        int exp_mag;
        int exp_ref;
        bit exp_ovr;
        int waited;
        a = (v < 0) ? -v : v;
        if (a >= FS - 1) begin
            exp_ovr = 1'b1; exp_mag = FS - 1; exp_ref = FS;
        end else begin
            exp_ovr = 1'b0; exp_mag = a + 1; exp_ref = a + 2;
        end
        @(posedge clk); #1;
        vin = v;
        len_rst = 0; len_in = 0; len_ref = 0; bbm_err = 0; gap_err = 0;
        done_cnt = 0; refp_seen = 1'b0; refn_seen = 1'b0;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        chk("R2 discharge begins after start", sw_dischg_o, 1);
        if (poke) begin
            repeat (100) @(posedge clk);
            #1;
            chk("R8 result held during conversion", mag_o, last_mag);
            start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        waited = 0;
        while (done_o !== 1'b1 && waited < 4000) begin
            @(posedge clk); #1;
            waited++;
        end
        if (waited >= 4000) begin
            chk("R6 conversion completes", 0, 1);
        end else begin
            chk("R6 or R7 magnitude", mag_o, exp_mag);
            chk("R7 overrange flag", ovr_o, exp_ovr);
            chk("R5 sign", sign_o, (v < 0));
            chk("R5 negative reference used", refn_seen, (v < 0));
            chk("R5 positive reference used", refp_seen, (v > 0));
            chk("R2 discharge length", len_rst, RST);
            chk("R4 run-up length", len_in, FS);
            chk("R6 or R7 run-down length", len_ref, exp_ref);
            chk("R3 overlapping selects", bbm_err, 0);
            chk("R3 gap cycles", gap_err, 0);
            chk("R8 done latency after reference drop", zeros, 1);
            chk("R8 last select was a reference", (last_nz == 4'b0010 || last_nz == 4'b0001), 1);
            @(posedge clk); #1;
            chk("R8 done is one cycle", done_o, 0);
            chk("R8 magnitude holds", mag_o, exp_mag);
            repeat (20) @(posedge clk);
            #1;
            chk("R9 no second discharge", len_rst, RST);
            chk("R9 single done", done_cnt, 1);
            chk("R9 selects idle", {sw_dischg_o, sw_inp_o, sw_refp_o, sw_refn_o}, 0);
            last_mag = mag_o;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 selects low", {sw_dischg_o, sw_inp_o, sw_refp_o, sw_refn_o}, 0);
        chk("R1 done low", done_o, 0);
        chk("R1 magnitude zero", mag_o, 0);
        chk("R1 sign zero", sign_o, 0);
        chk("R1 overrange zero", ovr_o, 0);

        // directed corners
        conv(1, 1'b0);
        conv(-1, 1'b0);
        conv(FS - 2, 1'b1);        // R7 crossing in the last permitted cycle
        conv(-(FS - 2), 1'b0);
        conv(FS - 1, 1'b0);        // R7 one cycle too late
        conv(-(FS - 1), 1'b1);
        conv(FS + 3, 1'b0);
        conv(37, 1'b1);            // R9 start during run-up

        for (int k = 0; k < 30; k++) begin
            int r;
            r = int'($urandom_range(0, 2 * (FS + 3))) - (FS + 3);
            if (r == 0) r = 1;
            conv(r, ($urandom_range(0, 3) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule